// File: doc/BRIEF.md
# Vector Mask Register Unit

This block keeps the bit-mask register of a vector coprocessor and carries out every operation that reads or rewrites that mask. The mask is `SECTION_SIZE` bits long, and a vector count input chooses how many leading bits are active. Mask bit 0 is the leftmost bit, which is the most significant bit of byte 0. Every operation looks only at the active prefix. Every operation that writes the mask also clears each bit from the vector count onward.

Each operation starts with a one-cycle strobe that carries an opcode. The operations are:

- testing the mask,
- complementing it,
- counting its leading zeros,
- counting its ones,
- loading it from the parallel operand input,
- loading the inverted operand,
- combining it with the operand by AND, OR or XOR.

On the next cycle the block raises a one-cycle done pulse. In that cycle it shows three results: the updated mask, a 2-bit condition code that says whether the active bits are all zero, all one or mixed, and a 32-bit count for the counting operations. Memory access, address generation and the rest of the vector status state stay with the surrounding coprocessor.

Top module: `vmask_unit`

## Requirements
- R1: After reset, maskOut, done, condCode and countOut are all zero.
- R2: A cycle with opValid high gives exactly one done pulse, in the following cycle. In that same cycle maskOut, condCode and countOut hold the results of that operation. A new operation may be strobed in every cycle, and it acts on the mask left by the one before it.
- R3: Only mask bits k < n are active, where n is the vector count with any value above SECTION_SIZE taken as SECTION_SIZE. After any operation that writes the mask (codes 1, 4, 5, 6, 7, 8), every bit k ≥ n is zero.
- R4: Mask bit k appears on maskOut[SECTION_SIZE-1-k], and operand bit k is taken from operand[SECTION_SIZE-1-k]. Byte 0 is therefore the top byte of each vector.
- R5: For codes 0 to 8, condCode is computed on the active bits of the mask after the operation. It is 0 if n is 0 or all active bits are zero, 3 if all active bits are one, and 1 if they are mixed. The value 2 never appears.
- R6: Test (code 0) leaves the whole mask unchanged, including the inactive bits, and returns count 0.
- R7: Count ones (code 3) returns the number of one bits among the active bits and leaves the mask unchanged.
- R8: Count leading zeros (code 2) returns the number of zero bits before the first active one bit, or n if there is none, and leaves the mask unchanged.
- R9: Complement (code 1) inverts the active bits of the mask.
- R10: Load (code 4) copies the active operand bits into the mask. Load complement (code 5) inverts the operand bits before the inactive bits are cleared.
- R11: Codes 6, 7 and 8 replace the active bits with the mask AND, OR and XOR the operand, respectively.
- R12: Codes 9 to 15 leave the mask unchanged, return condCode 0 and count 0, and still produce the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | One-cycle operation strobe |
| opCode | input | 4 | Operation select |
| vecCount | input | $clog2(SECTION_SIZE)+1 | Vector count (number of active bits) |
| operand | input | SECTION_SIZE | Operand bits, mask bit 0 in the top position |
| maskOut | output | SECTION_SIZE | Current mask contents |
| done | output | 1 | Result-valid pulse |
| condCode | output | 2 | Uniformity code of the active bits |
| countOut | output | 32 | Count result for codes 2 and 3, else zero |

## Verification
The two functions that can fall in the same cycle are retiring one operation and accepting the next: the done pulse and result of one strobe appear in the cycle that the following strobe is sampled. That strobe must see the freshly written mask. The bench provokes this with unbroken runs of strobes, including a run that changes the vector count on every step. A reference model in the bench updates its own mask in the same order, so each done pulse is judged against the mask, code and count expected after exactly that sequence of writes. A done pulse with no pending expectation, or an expectation left unanswered at the end, counts as a failure.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

  localparam logic [3:0] OP_TEST   = 4'd0;
  localparam logic [3:0] OP_COMPL  = 4'd1;
  localparam logic [3:0] OP_LEAD   = 4'd2;
  localparam logic [3:0] OP_ONES   = 4'd3;
  localparam logic [3:0] OP_LOAD   = 4'd4;
  localparam logic [3:0] OP_LOADC  = 4'd5;
  localparam logic [3:0] OP_AND    = 4'd6;
  localparam logic [3:0] OP_OR     = 4'd7;
  localparam logic [3:0] OP_XOR    = 4'd8;

  typedef enum logic [1:0] {
    CMB_PASS = 2'd0,
    CMB_AND  = 2'd1,
    CMB_OR   = 2'd2,
    CMB_XOR  = 2'd3
  } combine_e;

  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_LEAD = 2'd1,
    CNT_ONES = 2'd2
  } cntsel_e;

  typedef struct packed {
    logic     go;
    logic     writeMask;
    logic     srcOperand;
    logic     invertSrc;
    combine_e combine;
    cntsel_e  cntSel;
    logic     reportCc;
  } ctl_t;

endpackage

// File: rtl/vmask_active.sv
module vmask_active #(
  parameter int SECTION_SIZE = 128,
  localparam int VCW = $clog2(SECTION_SIZE) + 1
) (
  input  logic [VCW-1:0]          vecCount,
  output logic [VCW-1:0]          clampCount,
  output logic [SECTION_SIZE-1:0] actMask
);

  localparam logic [VCW-1:0] MAX_COUNT = VCW'(SECTION_SIZE);

  assign clampCount = (vecCount > MAX_COUNT) ? MAX_COUNT : vecCount;

  // mask bit k lives at vector position SECTION_SIZE-1-k
  for (genvar gi = 0; gi < SECTION_SIZE; gi++) begin : g_act
    assign actMask[SECTION_SIZE-1-gi] = (VCW'(gi) < clampCount);
  end

endmodule

// File: rtl/vmask_stats.sv
module vmask_stats #(
  parameter int SECTION_SIZE = 128,
  localparam int VCW = $clog2(SECTION_SIZE) + 1
) (
  input  logic [SECTION_SIZE-1:0] bits,
  input  logic [VCW-1:0]          clampCount,
  output logic [VCW-1:0]          onesCnt,
  output logic [VCW-1:0]          leadCnt,
  output logic [1:0]              ccOut
);

  logic seen;

  always_comb begin
    onesCnt = '0;
    leadCnt = clampCount;
    seen    = 1'b0;
    for (int k = 0; k < SECTION_SIZE; k++) begin
      if (bits[SECTION_SIZE-1-k]) begin
        onesCnt = onesCnt + VCW'(1);
        if (!seen) begin
          leadCnt = VCW'(k);
          seen    = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (clampCount == '0 || onesCnt == '0) begin
      ccOut = 2'd0;
    end else if (onesCnt == clampCount) begin
      ccOut = 2'd3;
    end else begin
      ccOut = 2'd1;
    end
  end

endmodule

// File: rtl/vmask_ctrl.sv
module vmask_ctrl
  import vmask_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  output ctl_t       ctl,
  output logic       done
);

  logic doneQ;

  always_comb begin
    ctl    = '0;
    ctl.go = opValid;
    if (opValid) begin
      case (opCode)
        OP_TEST: begin
          ctl.reportCc = 1'b1;
        end
        OP_COMPL: begin
          ctl.writeMask = 1'b1;
          ctl.invertSrc = 1'b1;
          ctl.reportCc  = 1'b1;
        end
        OP_LEAD: begin
          ctl.cntSel   = CNT_LEAD;
          ctl.reportCc = 1'b1;
        end
        OP_ONES: begin
          ctl.cntSel   = CNT_ONES;
          ctl.reportCc = 1'b1;
        end
        OP_LOAD: begin
          ctl.writeMask  = 1'b1;
          ctl.srcOperand = 1'b1;
          ctl.reportCc   = 1'b1;
        end
        OP_LOADC: begin
          ctl.writeMask  = 1'b1;
          ctl.srcOperand = 1'b1;
          ctl.invertSrc  = 1'b1;
          ctl.reportCc   = 1'b1;
        end
        OP_AND: begin
          ctl.writeMask = 1'b1;
          ctl.combine   = CMB_AND;
          ctl.reportCc  = 1'b1;
        end
        OP_OR: begin
          ctl.writeMask = 1'b1;
          ctl.combine   = CMB_OR;
          ctl.reportCc  = 1'b1;
        end
        OP_XOR: begin
          ctl.writeMask = 1'b1;
          ctl.combine   = CMB_XOR;
          ctl.reportCc  = 1'b1;
        end
        default: begin
          ctl.reportCc = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= opValid;
  end

  assign done = doneQ;

  // R2: a strobe is answered by done in the next cycle
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> doneQ);

  // R2: no done without a strobe in the cycle before
  a_r2_done_only: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !doneQ);

endmodule

// File: rtl/vmask_dpath.sv
module vmask_dpath
  import vmask_pkg::*;
#(
  parameter int SECTION_SIZE = 128,
  localparam int VCW = $clog2(SECTION_SIZE) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic [VCW-1:0]          vecCount,
  input  logic [SECTION_SIZE-1:0] operand,
  output logic [SECTION_SIZE-1:0] maskOut,
  output logic [1:0]              condCode,
  output logic [31:0]             countOut
);

  logic [SECTION_SIZE-1:0] maskQ;
  logic [1:0]              ccQ;
  logic [31:0]             countQ;
  logic                    primedQ;

  logic [SECTION_SIZE-1:0] actMask;
  logic [VCW-1:0]          clampCount;
  logic [SECTION_SIZE-1:0] srcVec;
  logic [SECTION_SIZE-1:0] combined;
  logic [SECTION_SIZE-1:0] newMask;
  logic [SECTION_SIZE-1:0] activeBits;
  logic [VCW-1:0]          onesCnt;
  logic [VCW-1:0]          leadCnt;
  logic [1:0]              statCc;

  vmask_active #(.SECTION_SIZE(SECTION_SIZE)) u_active (
    .vecCount   (vecCount),
    .clampCount (clampCount),
    .actMask    (actMask)
  );

  always_comb begin
    srcVec = ctl.srcOperand ? operand : maskQ;
    if (ctl.invertSrc) srcVec = ~srcVec;
    case (ctl.combine)
      CMB_AND: combined = maskQ & operand;
      CMB_OR:  combined = maskQ | operand;
      CMB_XOR: combined = maskQ ^ operand;
      default: combined = srcVec;
    endcase
    newMask = ctl.writeMask ? (combined & actMask) : maskQ;
  end

  assign activeBits = newMask & actMask;

  vmask_stats #(.SECTION_SIZE(SECTION_SIZE)) u_stats (
    .bits       (activeBits),
    .clampCount (clampCount),
    .onesCnt    (onesCnt),
    .leadCnt    (leadCnt),
    .ccOut      (statCc)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      ccQ     <= 2'd0;
      countQ  <= '0;
      primedQ <= 1'b0;
    end else begin
      primedQ <= 1'b1;
      if (ctl.go) begin
        maskQ <= newMask;
        ccQ   <= ctl.reportCc ? statCc : 2'd0;
        case (ctl.cntSel)
          CNT_LEAD: countQ <= 32'(leadCnt);
          CNT_ONES: countQ <= 32'(onesCnt);
          default:  countQ <= '0;
        endcase
      end
    end
  end

  assign maskOut  = maskQ;
  assign condCode = ccQ;
  assign countOut = countQ;

  // R3: bits beyond the count are clear after a writing operation
  a_r3_inactive_clear: assert property (@(posedge clk) disable iff (!rstN)
    primedQ && $past(ctl.go && ctl.writeMask) |-> (maskQ & ~$past(actMask)) == '0);

  // R6: non-writing operations keep the whole mask
  a_r6_mask_held: assert property (@(posedge clk) disable iff (!rstN)
    primedQ && $past(ctl.go && !ctl.writeMask) |-> maskQ == $past(maskQ));

  // R5: empty active prefix reports code 0
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    primedQ && $past(ctl.go) && $past(clampCount) == '0 |-> ccQ == 2'd0);

  // R5: code 2 never reported
  a_r5_no_code2: assert property (@(posedge clk) disable iff (!rstN)
    ccQ != 2'd2);

  // R7, R8: counts never exceed the active length
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    primedQ && $past(ctl.go) |-> countQ <= 32'($past(clampCount)));

endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int SECTION_SIZE = 128,
  localparam int VCW = $clog2(SECTION_SIZE) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    opValid,
  input  logic [3:0]              opCode,
  input  logic [VCW-1:0]          vecCount,
  input  logic [SECTION_SIZE-1:0] operand,
  output logic [SECTION_SIZE-1:0] maskOut,
  output logic                    done,
  output logic [1:0]              condCode,
  output logic [31:0]             countOut
);

  ctl_t ctl;

  vmask_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .ctl     (ctl),
    .done    (done)
  );

  vmask_dpath #(.SECTION_SIZE(SECTION_SIZE)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .vecCount (vecCount),
    .operand  (operand),
    .maskOut  (maskOut),
    .condCode (condCode),
    .countOut (countOut)
  );

endmodule

// File: tb/vmask_unit_tb.sv
module vmask_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SS = 128;
  localparam int VCW = $clog2(SS) + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [3:0]    opCode = '0;
  logic [VCW-1:0] vecCount = '0;
  logic [SS-1:0] operand = '0;
  logic [SS-1:0] maskOut;
  logic          done;
  logic [1:0]    condCode;
  logic [31:0]   countOut;

  int total = 0;
  int bad = 0;

  logic [SS-1:0] mdl = '0;
  logic [SS-1:0] qMask[$];
  logic [1:0]    qCc[$];
  logic [31:0]   qCnt[$];
  string         qTag[$];

  vmask_unit #(.SECTION_SIZE(SS)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .vecCount(vecCount), .operand(operand), .maskOut(maskOut),
    .done(done), .condCode(condCode), .countOut(countOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [SS-1:0] act,
                       input logic [SS-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of one operation; bit k at position SS-1-k
  task automatic doOp(input logic [3:0] op, input int vc, input logic [SS-1:0] opnd,
                      input string tag);
    int n;
    int ones;
    int lead;
    logic [SS-1:0] nm;
    logic [1:0] cc;
    logic [31:0] cnt;
    n  = (vc > SS) ? SS : vc;
    nm = mdl;
    for (int k = 0; k < SS; k++) begin
      logic mb;
      logic ob;
      mb = mdl[SS-1-k];
      ob = opnd[SS-1-k];
      if (op == 1 || (op >= 4 && op <= 8)) begin
        if (k >= n) nm[SS-1-k] = 1'b0;
        else case (op)
          1: nm[SS-1-k] = ~mb;
          4: nm[SS-1-k] = ob;
          5: nm[SS-1-k] = ~ob;
          6: nm[SS-1-k] = mb & ob;
          7: nm[SS-1-k] = mb | ob;
          default: nm[SS-1-k] = mb ^ ob;
        endcase
      end
    end
    ones = 0;
    lead = n;
    for (int k = n - 1; k >= 0; k--) begin
      if (nm[SS-1-k]) begin
        ones++;
        lead = k;
      end
    end
    if (op > 8) cc = 2'd0;
    else if (n == 0 || ones == 0) cc = 2'd0;
    else if (ones == n) cc = 2'd3;
    else cc = 2'd1;
    cnt = (op == 2) ? 32'(lead) : (op == 3) ? 32'(ones) : 32'd0;
    mdl = nm;
    qMask.push_back(nm);
    qCc.push_back(cc);
    qCnt.push_back(cnt);
    qTag.push_back(tag);
    @(negedge clk);
    opValid  = 1'b1;
    opCode   = op;
    vecCount = VCW'(vc);
    operand  = opnd;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      opValid = 1'b0;
      opCode  = '0;
      operand = '0;
    end
  endtask

  // monitor: compare each done against the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rstN && done) begin
        if (qTag.size() == 0) begin
          check(1'b0, "R2 unexpected done", SS'(done), '0);
        end else begin
          logic [SS-1:0] em;
          logic [1:0] ec;
          logic [31:0] en;
          string t;
          em = qMask.pop_front();
          ec = qCc.pop_front();
          en = qCnt.pop_front();
          t  = qTag.pop_front();
          check(maskOut === em, {t, " mask"}, maskOut, em);
          check(condCode === ec, {t, " cc"}, SS'(condCode), SS'(ec));
          check(countOut === en, {t, " count"}, SS'(countOut), SS'(en));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [SS-1:0] ones128;
    logic [SS-1:0] patA;
    logic [SS-1:0] patB;
    ones128 = '1;
    patA = {16{8'hA5}};
    patB = {8{16'h0FF0}};

    repeat (3) @(negedge clk);
    // R1 reset state
    check(maskOut === '0, "R1 mask", maskOut, '0);
    check(done === 1'b0, "R1 done", SS'(done), '0);
    check(condCode === 2'd0, "R1 cc", SS'(condCode), '0);
    check(countOut === 32'd0, "R1 count", SS'(countOut), '0);
    rstN = 1'b1;
    idle(2);

    doOp(4, 128, ones128, "R10 load full");
    doOp(0, 128, '0, "R6 test all ones");
    doOp(3, 128, '0, "R7 ones full");
    doOp(0, 0, '0, "R5 test empty count");
    doOp(3, 0, '0, "R7 ones empty count");
    doOp(2, 0, '0, "R8 lead empty count");
    idle(1);
    doOp(4, 10, ones128, "R3 load short count");
    doOp(0, 12, '0, "R5 mixed test");
    doOp(2, 12, '0, "R8 lead first bit set");
    doOp(1, 12, '0, "R9 complement");
    doOp(2, 12, '0, "R8 lead after complement");
    doOp(2, 8, '0, "R8 lead no one bit");
    doOp(4, 16, {8'h01, 8'h80, 112'h0}, "R4 byte order load");
    doOp(2, 16, '0, "R4 lead in byte 0");
    doOp(5, 20, patA, "R10 load complement");
    doOp(6, 13, patB, "R11 and");
    doOp(7, 128, patA, "R11 or");
    doOp(8, 7, patB, "R11 xor");
    doOp(4, 200, ones128, "R3 count above section");
    doOp(3, 200, '0, "R7 ones clamped");
    doOp(9, 40, '0, "R12 code 9");
    doOp(15, 5, ones128, "R12 code 15");
    doOp(4, 1, ones128, "R5 single bit");
    doOp(2, 1, '0, "R8 single one");
    idle(2);
    doOp(4, 128, patA, "R6 load wide");
    doOp(0, 3, '0, "R6 test keeps inactive");
    doOp(3, 128, '0, "R6 inactive bits kept");
    idle(1);

    // back-to-back random run, R2
    for (int i = 0; i < 80; i++) begin
      int op;
      int vc;
      op = ($urandom_range(0, 9) == 9) ? $urandom_range(9, 15) : $urandom_range(0, 8);
      vc = $urandom_range(0, 140);
      doOp(4'(op), vc, {$urandom(), $urandom(), $urandom(), $urandom()}, "R2 stream");
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(3);
    check(qTag.size() == 0, "R2 pending results", SS'(qTag.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule